// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block is a core-local timer. It holds one 64-bit time counter that counts freely and one 64-bit compare register for each hart. For each hart it drives a level interrupt. That interrupt stays high for as long as the counter is at or above that hart's compare value. The `NUM_HARTS` parameter sets the number of harts. The platform places the register window at any base address; the block decodes only the 15-bit offset inside a 32 KiB window.

Software reaches the block through a plain 32-bit register port. Each 64-bit register appears as two words: the low half at its offset and the high half at offset +4. The compare registers form an array that starts at offset 0x0000, with an 8-byte stride for each hart. The counter sits at the top of the window, at 0x7FF8. The counter advances only in cycles where the tick-enable input is high, so the platform can drive that input with a divided time base.

Top module: `mtimer_unit`

## Requirements
- R1: After synchronous reset the counter is zero, every compare register holds all ones, and no interrupt output is high.
- R2: The counter increases by exactly one on each clock edge where `tick_en` is high and no counter write occurs. It holds its value when `tick_en` is low.
- R3: A write to offset 0x7FF8 (low word) or 0x7FFC (high word) replaces that counter half and leaves the other half as it was. In that cycle the write takes the place of the increment, even if `tick_en` is high.
- R4: The compare register for hart N is at offset 8*N (low word) and 8*N+4 (high word). A write changes only the addressed half of that one hart's register.
- R5: `timer_irq[N]` is high exactly when the unsigned 64-bit counter is greater than or equal to compare[N]. This includes equality. The output follows a counter or compare write by the next cycle, and it drops once a larger compare value is written.
- R6: Read data is registered. It shows the addressed word in the cycle after `bus_re` is high, and it is zero in the cycle after any cycle where `bus_re` is low.
- R7: A read of an offset whose hart index (offset bits 14:3) is at or above `NUM_HARTS`, other than the counter index 0xFFF, returns zero. A write to such an offset changes no register.
- R8: Counting and comparing use the full 64 bits. The low word carries into the high word, and a compare decides on the high word before the low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| bus_addr | input | 15 | Byte offset within the register window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_re` |
| timer_irq | output | NUM_HARTS | Level timer interrupt, one bit per hart |

## Verification
The bench targets the equality point of the compare: a design that used a strict greater-than would hold the interrupt low when the counter exactly reaches its target. It drives the counter across the 32-bit boundary; a design without the carry would wrap to zero. It then writes a counter half in a cycle where `tick_en` is also high; a design that gave priority to the increment, or that let the increment disturb the other half, would read back an off-by-one value. It also writes and reads hart slots past `NUM_HARTS`; a design with loose decoding would alias those accesses onto a real compare register and corrupt another hart's interrupt.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 64;
    localparam int ADDR_W = 15;
    localparam int IDX_W  = ADDR_W - 3;

    localparam logic [IDX_W-1:0] CNT_IDX = '1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_CNT  = 2'd2
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } dec_t;

    function automatic logic [CNT_W-1:0] merge_half(
        input logic [CNT_W-1:0]  cur,
        input logic              hi,
        input logic [WORD_W-1:0] w
    );
        return hi ? {w, cur[WORD_W-1:0]} : {cur[CNT_W-1:WORD_W], w};
    endfunction

    function automatic logic [WORD_W-1:0] pick_half(
        input logic [CNT_W-1:0] v,
        input logic             hi
    );
        return hi ? v[CNT_W-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
    import mtimer_pkg::*;
#(
    parameter int NUM_HARTS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [IDX_W-1:0] idx;

    assign idx = addr[ADDR_W-1:3];

    always_comb begin
        dec.idx = idx;
        dec.hi  = addr[2];
        if (idx == CNT_IDX)
            dec.sel = SEL_CNT;
        else if (32'(idx) < NUM_HARTS)
            dec.sel = SEL_CMP;
        else
            dec.sel = SEL_NONE;
    end
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter
    import mtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wr_en)
            cnt <= merge_half(cnt, wr_hi, wdata);
        else if (tick_en)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/mtimer_cmp_slot.sv
module mtimer_cmp_slot
    import mtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cmp,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst)
            cmp <= '1;
        else if (wr_en)
            cmp <= merge_half(cmp, wr_hi, wdata);
    end

    assign irq = (cnt >= cmp);
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
    import mtimer_pkg::*;
#(
    parameter int NUM_HARTS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic [14:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_we,
    input  logic                 bus_re,
    output logic [31:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] timer_irq
);
    dec_t             dec;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_all [NUM_HARTS];
    logic [CNT_W-1:0] cmp_sel;
    logic             cnt_wr;
    logic [WORD_W-1:0] rdata_q;

    mtimer_decode #(.NUM_HARTS(NUM_HARTS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign cnt_wr = bus_we && (dec.sel == SEL_CNT);

    mtimer_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_en   (cnt_wr),
        .wr_hi   (dec.hi),
        .wdata   (bus_wdata),
        .cnt     (cnt_q)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
        logic slot_wr;
        assign slot_wr = bus_we && (dec.sel == SEL_CMP) && (dec.idx == IDX_W'(h));
        mtimer_cmp_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (slot_wr),
            .wr_hi (dec.hi),
            .wdata (bus_wdata),
            .cnt   (cnt_q),
            .cmp   (cmp_all[h]),
            .irq   (timer_irq[h])
        );
    end

    always_comb begin
        cmp_sel = '0;
        for (int h = 0; h < NUM_HARTS; h++)
            if (dec.idx == IDX_W'(h))
                cmp_sel = cmp_all[h];
    end

    always_ff @(posedge clk) begin
        if (rst || !bus_re)
            rdata_q <= '0;
        else begin
            unique case (dec.sel)
                SEL_CNT:  rdata_q <= pick_half(cnt_q, dec.hi);
                SEL_CMP:  rdata_q <= pick_half(cmp_sel, dec.hi);
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/mtimer_unit_chk.sv
module mtimer_unit_chk #(
    parameter int NUM_HARTS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_en,
    input logic [14:0]          bus_addr,
    input logic [31:0]          bus_wdata,
    input logic                 bus_we,
    input logic                 bus_re,
    input logic [31:0]          bus_rdata,
    input logic [NUM_HARTS-1:0] timer_irq,
    input logic [63:0]          cnt_q
);
    logic at_cnt;
    logic at_hole;
    logic cnt_wr;

    assign at_cnt  = (bus_addr[14:3] == 12'hFFF);
    assign at_hole = !at_cnt && (32'(bus_addr[14:3]) >= NUM_HARTS);
    assign cnt_wr  = bus_we && at_cnt;

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt_q == 64'd0 && timer_irq == '0));                       // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_wr) |=> cnt_q == $past(cnt_q) + 64'd1);            // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cnt_wr) |=> $stable(cnt_q));                          // R2

    AST_CNT_WR_LO: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !bus_addr[2]) |=>
        (cnt_q[31:0] == $past(bus_wdata) && cnt_q[63:32] == $past(cnt_q[63:32]))); // R3

    AST_CNT_WR_HI: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && bus_addr[2]) |=>
        (cnt_q[63:32] == $past(bus_wdata) && cnt_q[31:0] == $past(cnt_q[31:0]))); // R3

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> bus_rdata == 32'd0);                                    // R6

    AST_RD_CNT_LO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && at_cnt && !bus_addr[2]) |=> bus_rdata == $past(cnt_q[31:0])); // R6

    AST_RD_HOLE: assert property (@(posedge clk) disable iff (rst)
        (bus_re && at_hole) |=> bus_rdata == 32'd0);                        // R7
endmodule

bind mtimer_unit mtimer_unit_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .timer_irq (timer_irq),
    .cnt_q     (cnt_q)
);

// File: tb/mtimer_unit_test.sv
`timescale 1ns/1ps
module mtimer_unit_test;
    localparam int HARTS = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_en = 1'b0;
    logic [14:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic             bus_we = 1'b0;
    logic             bus_re = 1'b0;
    logic [31:0]      bus_rdata;
    logic [HARTS-1:0] timer_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic  re_d = 1'b0;

    mtimer_unit #(.NUM_HARTS(HARTS)) uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .timer_irq (timer_irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) re_d <= bus_re;

    // monitor: compares registered read data one cycle after the strobe
    always @(negedge clk) begin
        if (re_d) begin
            item_t it;
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL %s: unexpected read data act=%h exp=<none>", "R6", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s: act=%h exp=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [14:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [14:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: act=timeout exp=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(timer_irq), 32'd0);
        rd(15'h7FF8, 32'd0, "R1 cnt lo");
        rd(15'h7FFC, 32'd0, "R1 cnt hi");
        rd(15'h0000, 32'hFFFF_FFFF, "R1 cmp0 lo");
        rd(15'h0014, 32'hFFFF_FFFF, "R1 cmp2 hi");

        // R2 counting and holding
        ticks(10);
        rd(15'h7FF8, 32'd10, "R2 count");
        repeat (5) @(negedge clk);
        rd(15'h7FF8, 32'd10, "R2 hold");

        // R4 half writes
        wr(15'h0000, 32'd20);
        @(negedge clk);
        rd(15'h0004, 32'hFFFF_FFFF, "R4 hi untouched");
        wr(15'h0004, 32'd0);
        rd(15'h0000, 32'd20, "R4 cmp0 lo");
        rd(15'h0004, 32'd0, "R4 cmp0 hi");
        rd(15'h0008, 32'hFFFF_FFFF, "R4 cmp1 untouched");
        chk("R5 below", 32'(timer_irq), 32'd0);

        // R5 equality boundary
        ticks(9);
        chk("R5 cnt=19", 32'(timer_irq), 32'd0);
        ticks(1);
        chk("R5 cnt=20 equal", 32'(timer_irq), 32'b001);
        wr(15'h0000, 32'd100);
        chk("R5 drop on larger cmp", 32'(timer_irq), 32'd0);

        // R8 carry across words
        wr(15'h7FF8, 32'hFFFF_FFFF);
        chk("R5 cnt write raises", 32'(timer_irq), 32'b001);
        ticks(1);
        rd(15'h7FF8, 32'd0, "R8 carry lo");
        rd(15'h7FFC, 32'd1, "R8 carry hi");

        // R3 write wins over tick
        tick_en = 1'b1;
        wr(15'h7FF8, 32'd5);
        tick_en = 1'b0;
        rd(15'h7FF8, 32'd5, "R3 lo write over tick");
        rd(15'h7FFC, 32'd1, "R3 hi kept");
        chk("R8 hi word compare", 32'(timer_irq), 32'b001);
        tick_en = 1'b1;
        wr(15'h7FFC, 32'd0);
        tick_en = 1'b0;
        rd(15'h7FF8, 32'd5, "R3 lo kept on hi write");
        rd(15'h7FFC, 32'd0, "R3 hi write");
        chk("R5 after cnt hi write", 32'(timer_irq), 32'd0);

        // R7 unmapped slots
        wr(15'h0018, 32'd0);
        wr(15'h001C, 32'd0);
        wr(15'h7FF0, 32'd0);
        chk("R7 irq unchanged", 32'(timer_irq), 32'd0);
        rd(15'h0018, 32'd0, "R7 hart3 lo");
        rd(15'h001C, 32'd0, "R7 hart3 hi");
        rd(15'h7FF0, 32'd0, "R7 hart4094");
        rd(15'h0010, 32'hFFFF_FFFF, "R7 cmp2 lo intact");
        rd(15'h0000, 32'd100, "R7 cmp0 intact");

        // R4/R5 second hart
        wr(15'h000C, 32'd0);
        wr(15'h0008, 32'd3);
        chk("R5 hart1", 32'(timer_irq), 32'b010);
        rd(15'h0008, 32'd3, "R4 cmp1 lo");

        // R6 idle read data
        @(negedge clk);
        chk("R6 idle zero", bus_rdata, 32'd0);
        chk("R6 queue drained", 32'(sb_q.size()), 32'd0);

        summary();
    end
endmodule